// File: doc/BRIEF.md
# AC-Link Left-Channel Sample Extractor

This block listens passively to the codec-to-controller serial line of an AC'97 style link. It watches the bit clock, the frame marker (SYNC) and the serial input data. From every frame whose slot-valid tag for slot 3 is set, it takes the 16-bit left-channel PCM word and turns the frames into a free-running sample stream. No processor or bus read sits in that path.

The block has two clock domains. All frame tracking runs on the falling edge of the bit clock. Each captured word then crosses a four-entry asynchronous FIFO into the system clock domain. There the consumer sees a valid/ready stream. Each rising edge of SYNC also becomes a one-cycle tick in the system domain, at the 48 kHz frame rate, which serves as the enable for downstream spectrum hardware. If the consumer stalls long enough for the FIFO to fill, further samples are dropped and a sticky overflow flag is raised.

Top module: `pcm_tap`

## Requirements
- R1: Captured samples appear on `sample_data` with `sample_valid` high, in the order their frames arrived. A presented sample stays on the port unchanged until it is taken, which happens in a system cycle where `sample_ready` is high.
- R2: The data line and SYNC are sampled on the falling edge of `bit_clk`. Frame position 0 is the first bit sampled with SYNC high after SYNC was sampled low. The sample is made of the bits at frame positions 56 through 71.
- R3: A frame produces a sample only if the bit at frame position 3 (the slot 3 valid tag) is 1. Otherwise no sample is produced for that frame.
- R4: Bits are taken MSB first. Position 56 becomes `sample_data[15]` and position 71 becomes `sample_data[0]`.
- R5: Every SYNC rise produces exactly one `frame_tick` pulse, one system cycle wide, whether or not the frame carries a sample.
- R6: A SYNC rise always restarts the frame at position 0. A frame cut short by a new SYNC rise before position 71 was sampled produces no sample.
- R7: After 256 bit positions without a new SYNC rise, the data line is ignored until the next SYNC rise.
- R8: The FIFO holds 4 samples. A sample that arrives while the FIFO is full is dropped and sets `overflow`. The flag stays set until reset. Samples already stored are delivered intact.
- R9: While `rst_n` is low, `sample_valid`, `overflow` and `frame_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bit_clk | input | 1 | Serial link bit clock |
| sync_in | input | 1 | Frame marker from the link |
| sdata_in | input | 1 | Serial data from the codec |
| sys_clk | input | 1 | Consumer clock |
| sample_ready | input | 1 | Consumer accepts the presented sample |
| sample_data | output | 16 | Left-channel PCM sample |
| sample_valid | output | 1 | A sample is presented |
| frame_tick | output | 1 | One-cycle pulse per frame |
| overflow | output | 1 | Sticky: a sample was dropped on a full FIFO |

## Verification
The four boundary words 0x0000, 0xFFFF, 0x8000 and 0x0001 are sent to catch a reversed or shifted bit order. A one-position slip of the capture window would corrupt every random word. Frames with the slot 3 tag cleared are mixed into the random traffic; a design that ignored the tag would emit words the bench never expected. Frames cut off by an early SYNC after 40, 71 and 72 bits probe the exact edge of the capture window. A long run of ones with no SYNC after a frame would trigger a second, phantom capture in a design whose bit counter wraps instead of stopping. The consumer is then stalled through six tagged frames. A design that overwrote stored data, lost the stalled word or cleared the flag would deliver the wrong first four words or show `overflow` low.

// File: rtl/pcm_tap_pkg.sv
package pcm_tap_pkg;

  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_FRAME = 1'b1
  } rx_state_e;

  localparam int unsigned LINK_FRAME_BITS = 256;
  localparam int unsigned LINK_TAG_POS    = 3;
  localparam int unsigned LINK_LEFT_POS   = 56;
  localparam int unsigned LINK_SAMPLE_W   = 16;

endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/pcm_sync2.sv
module pcm_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;

endmodule

// File: rtl/pcm_frame_rx.sv
module pcm_frame_rx
  import pcm_tap_pkg::*;
#(
  parameter int SW         = LINK_SAMPLE_W,
  parameter int FRAME_BITS = LINK_FRAME_BITS,
  parameter int TAG_POS    = LINK_TAG_POS,
  parameter int LEFT_POS   = LINK_LEFT_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic          sdata_i,
  output logic          push_o,
  output logic [SW-1:0] sample_o,
  output logic          frame_tgl_o
);

  localparam int CW       = $clog2(FRAME_BITS + 1);
  localparam int LAST_POS = LEFT_POS + SW - 1;

  rx_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            sync_q;
  logic            tag_q, tag_d;
  logic [SW-2:0]   sh_q, sh_d;
  logic            push_q, push_d;
  logic [SW-1:0]   sample_q, sample_d;
  logic            tgl_q, tgl_d;

  logic            rise;
  logic            active;
  logic [CW-1:0]   pos;

  always_comb begin
    rise     = sync_i & ~sync_q;
    active   = rise | (state_q == RX_FRAME);
    pos      = rise ? '0 : cnt_q;

    state_d  = state_q;
    cnt_d    = cnt_q;
    tag_d    = tag_q;
    sh_d     = sh_q;
    push_d   = 1'b0;
    sample_d = sample_q;
    tgl_d    = tgl_q;

    if (rise) begin
      state_d = RX_FRAME;
      cnt_d   = CW'(1);
      tgl_d   = ~tgl_q;
    end else if (state_q == RX_FRAME) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == CW'(FRAME_BITS - 1)) begin
        state_d = RX_IDLE;
      end
    end

    if (active) begin
      if (pos == CW'(TAG_POS)) begin
        tag_d = sdata_i;
      end
      if ((pos >= CW'(LEFT_POS)) && (pos < CW'(LAST_POS))) begin
        sh_d = {sh_q[SW-3:0], sdata_i};
      end
      if ((pos == CW'(LAST_POS)) && tag_q) begin
        push_d   = 1'b1;
        sample_d = {sh_q, sdata_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      sync_q   <= 1'b0;
      tag_q    <= 1'b0;
      sh_q     <= '0;
      push_q   <= 1'b0;
      sample_q <= '0;
      tgl_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sync_q  <= sync_i;
      tag_q   <= tag_d;
      sh_q    <= sh_d;
      push_q  <= push_d;
      tgl_q   <= tgl_d;
      if (push_d) begin
        sample_q <= sample_d;
      end
    end
  end

  assign push_o      = push_q;
  assign sample_o    = sample_q;
  assign frame_tgl_o = tgl_q;

endmodule

// File: rtl/pcm_async_fifo.sv
module pcm_async_fifo #(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input  logic         wr_clk,
  input  logic         wr_rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         wr_overflow,
  input  logic         rd_clk,
  input  logic         rd_rst_n,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_empty
);

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];

  logic [PW-1:0] wr_bin_q, wr_gray_q, wr_bin_nx, wr_gray_nx;
  logic [PW-1:0] rd_bin_q, rd_gray_q, rd_bin_nx, rd_gray_nx;
  logic [PW-1:0] rd_gray_w, wr_gray_r;
  logic          full, do_wr, do_rd, ovf_q;

  pcm_sync2 #(.W(PW)) u_rd2wr (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rd_gray_q),
    .q     (rd_gray_w)
  );

  pcm_sync2 #(.W(PW)) u_wr2rd (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wr_gray_q),
    .q     (wr_gray_r)
  );

  always_comb begin
    wr_bin_nx  = wr_bin_q + PW'(1);
    wr_gray_nx = (wr_bin_nx >> 1) ^ wr_bin_nx;
    full       = (wr_gray_q == {~rd_gray_w[PW-1:PW-2], rd_gray_w[PW-3:0]});
    do_wr      = wr_en & ~full;
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (do_wr) begin
        wr_bin_q  <= wr_bin_nx;
        wr_gray_q <= wr_gray_nx;
      end
      if (wr_en && full) begin
        ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge wr_clk) begin
    if (do_wr) begin
      mem[wr_bin_q[AW-1:0]] <= wr_data;
    end
  end

  always_comb begin
    rd_bin_nx  = rd_bin_q + PW'(1);
    rd_gray_nx = (rd_bin_nx >> 1) ^ rd_bin_nx;
    rd_empty   = (rd_gray_q == wr_gray_r);
    do_rd      = rd_en & ~rd_empty;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
    end else if (do_rd) begin
      rd_bin_q  <= rd_bin_nx;
      rd_gray_q <= rd_gray_nx;
    end
  end

  assign rd_data     = mem[rd_bin_q[AW-1:0]];
  assign wr_overflow = ovf_q;

endmodule

// File: rtl/pcm_tap.sv
module pcm_tap
  import pcm_tap_pkg::*;
#(
  parameter int SAMPLE_W   = LINK_SAMPLE_W,
  parameter int FRAME_BITS = LINK_FRAME_BITS,
  parameter int TAG_POS    = LINK_TAG_POS,
  parameter int LEFT_POS   = LINK_LEFT_POS,
  parameter int FIFO_AW    = 2
) (
  input  logic                rst_n,
  input  logic                bit_clk,
  input  logic                sync_in,
  input  logic                sdata_in,
  input  logic                sys_clk,
  input  logic                sample_ready,
  output logic [SAMPLE_W-1:0] sample_data,
  output logic                sample_valid,
  output logic                frame_tick,
  output logic                overflow
);

  logic                cap_clk;
  logic                cap_rst_n;
  logic                sys_rst_n;
  logic                rx_push;
  logic [SAMPLE_W-1:0] rx_sample;
  logic                rx_tgl;
  logic                fifo_empty;
  logic                fifo_ovf;
  logic                tgl_s;
  logic                tgl_d_q;
  logic                ovf_s;

  assign cap_clk = ~bit_clk;

  pcm_rst_sync u_cap_rst (
    .clk     (cap_clk),
    .arst_n  (rst_n),
    .rst_n_o (cap_rst_n)
  );

  pcm_rst_sync u_sys_rst (
    .clk     (sys_clk),
    .arst_n  (rst_n),
    .rst_n_o (sys_rst_n)
  );

  pcm_frame_rx #(
    .SW         (SAMPLE_W),
    .FRAME_BITS (FRAME_BITS),
    .TAG_POS    (TAG_POS),
    .LEFT_POS   (LEFT_POS)
  ) u_rx (
    .clk         (cap_clk),
    .rst_n       (cap_rst_n),
    .sync_i      (sync_in),
    .sdata_i     (sdata_in),
    .push_o      (rx_push),
    .sample_o    (rx_sample),
    .frame_tgl_o (rx_tgl)
  );

  pcm_async_fifo #(
    .W  (SAMPLE_W),
    .AW (FIFO_AW)
  ) u_fifo (
    .wr_clk      (cap_clk),
    .wr_rst_n    (cap_rst_n),
    .wr_en       (rx_push),
    .wr_data     (rx_sample),
    .wr_overflow (fifo_ovf),
    .rd_clk      (sys_clk),
    .rd_rst_n    (sys_rst_n),
    .rd_en       (sample_ready),
    .rd_data     (sample_data),
    .rd_empty    (fifo_empty)
  );

  pcm_sync2 #(.W(1)) u_tick_sync (
    .clk   (sys_clk),
    .rst_n (sys_rst_n),
    .d     (rx_tgl),
    .q     (tgl_s)
  );

  pcm_sync2 #(.W(1)) u_ovf_sync (
    .clk   (sys_clk),
    .rst_n (sys_rst_n),
    .d     (fifo_ovf),
    .q     (ovf_s)
  );

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      tgl_d_q <= 1'b0;
    end else begin
      tgl_d_q <= tgl_s;
    end
  end

  assign frame_tick   = tgl_s ^ tgl_d_q;
  assign sample_valid = ~fifo_empty;
  assign overflow     = ovf_s;

endmodule

// File: rtl/pcm_tap_chk.sv
module pcm_tap_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                sys_clk,
  input logic                cap_clk,
  input logic                rst_n,
  input logic                sample_ready,
  input logic                sample_valid,
  input logic [SAMPLE_W-1:0] sample_data,
  input logic                frame_tick,
  input logic                overflow,
  input logic                rx_push
);

  // R1: a presented sample is held until taken
  p_hold_sample_r1: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (sample_valid && !sample_ready) |=> (sample_valid && $stable(sample_data)));

  // R6: pushes from the capture side are never back to back
  p_push_spacing_r6: assert property (@(posedge cap_clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

  // R5: the frame tick is a single-cycle pulse
  p_tick_single_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    frame_tick |=> !frame_tick);

  // R8: overflow stays set until reset
  p_no_overflow_clear_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9: reset silences the outputs
  p_reset_quiet_r9: assert property (@(posedge sys_clk)
    !rst_n |=> (!sample_valid && !overflow && !frame_tick));

endmodule

bind pcm_tap pcm_tap_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .sys_clk      (sys_clk),
  .cap_clk      (cap_clk),
  .rst_n        (rst_n),
  .sample_ready (sample_ready),
  .sample_valid (sample_valid),
  .sample_data  (sample_data),
  .frame_tick   (frame_tick),
  .overflow     (overflow),
  .rx_push      (rx_push)
);

// File: tb/test_pcm_tap.sv
`timescale 1ns/1ps
module test_pcm_tap;

  localparam int FIFO_DEPTH = 4;

  logic        rst_n;
  logic        bit_clk;
  logic        sync_in;
  logic        sdata_in;
  logic        sys_clk;
  logic        sample_ready;
  logic [15:0] sample_data;
  logic        sample_valid;
  logic        frame_tick;
  logic        overflow;

  int compared = 0;
  int mismatched = 0;
  int frames_sent = 0;
  int ticks_seen = 0;
  int stall_cnt = 0;
  bit stall = 0;
  logic [15:0] exp_q[$];

  pcm_tap i_pcm_tap (
    .rst_n        (rst_n),
    .bit_clk      (bit_clk),
    .sync_in      (sync_in),
    .sdata_in     (sdata_in),
    .sys_clk      (sys_clk),
    .sample_ready (sample_ready),
    .sample_data  (sample_data),
    .sample_valid (sample_valid),
    .frame_tick   (frame_tick),
    .overflow     (overflow)
  );

  initial sys_clk = 1'b0;
  always #5 sys_clk = ~sys_clk;
  initial bit_clk = 1'b0;
  always #20 bit_clk = ~bit_clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit value the bench drives at frame position p
  function automatic logic frame_bit(input logic [15:0] s, input logic tag, input int p);
    if (p == 3) return tag;
    if (p >= 56 && p <= 71) return s[71-p];
    return logic'($urandom_range(0, 1));
  endfunction

  // a frame yields a sample when tagged and position 71 was reached
  function automatic bit yields_sample(input logic tag, input int nbits);
    return (tag == 1'b1) && (nbits >= 72);
  endfunction

  task automatic expect_sample(input logic [15:0] s);
    if (stall) begin
      if (stall_cnt < FIFO_DEPTH) exp_q.push_back(s);
      stall_cnt++;
    end else begin
      exp_q.push_back(s);
    end
  endtask

  task automatic send_frame(input logic [15:0] s, input logic tag, input int nbits);
    frames_sent++;
    if (yields_sample(tag, nbits)) expect_sample(s);
    for (int p = 0; p < nbits; p++) begin
      @(posedge bit_clk);
      #2;
      sync_in  = (p < 16);
      sdata_in = frame_bit(s, tag, p);
    end
  endtask

  task automatic send_gap(input int nbits, input bit ones);
    for (int p = 0; p < nbits; p++) begin
      @(posedge bit_clk);
      #2;
      sync_in  = 1'b0;
      sdata_in = ones ? 1'b1 : logic'($urandom_range(0, 1));
    end
  endtask

  // scoreboard: R1 R2 R3 R4
  always @(negedge sys_clk) begin
    if (rst_n && frame_tick) ticks_seen++;
    if (rst_n && sample_valid && sample_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected sample", {16'h0, sample_data}, 32'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(sample_data == e, "R1 R2 R4 sample value", {16'h0, sample_data}, {16'h0, e});
      end
    end
  end

  initial begin
    #(150000 * 10);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n        = 1'b0;
    sync_in      = 1'b0;
    sdata_in     = 1'b0;
    sample_ready = 1'b1;
    repeat (20) @(posedge sys_clk);
    @(negedge sys_clk);
    check(sample_valid == 1'b0, "R9 valid in reset", {31'h0, sample_valid}, 32'h0);
    check(overflow == 1'b0, "R9 overflow in reset", {31'h0, overflow}, 32'h0);
    check(frame_tick == 1'b0, "R9 tick in reset", {31'h0, frame_tick}, 32'h0);
    rst_n = 1'b1;
    send_gap(8, 1'b0);

    // R4 boundary words, MSB-first order
    send_frame(16'h0000, 1'b1, 256);
    send_frame(16'hFFFF, 1'b1, 256);
    send_frame(16'h8000, 1'b1, 256);
    send_frame(16'h0001, 1'b1, 256);

    // R2 R3 random words with mixed tags
    for (int i = 0; i < 20; i++) begin
      send_frame(16'($urandom), logic'($urandom_range(0, 3) != 0), 256);
    end
    send_frame(16'h1234, 1'b0, 256);
    send_gap(40, 1'b0);
    check(exp_q.size() == 0, "R1 all words delivered", exp_q.size(), 32'h0);
    check(ticks_seen == frames_sent, "R5 tick per frame", ticks_seen, frames_sent);

    // R6 truncated frames around the capture window edge
    send_frame(16'hDEAD, 1'b1, 40);
    send_frame(16'hBEEF, 1'b1, 71);
    send_frame(16'hCAFE, 1'b1, 72);
    send_frame(16'h5A5A, 1'b1, 256);
    send_gap(40, 1'b0);
    check(exp_q.size() == 0, "R6 truncated frames", exp_q.size(), 32'h0);
    check(ticks_seen == frames_sent, "R5 R6 tick on every rise", ticks_seen, frames_sent);

    // R7 long idle of ones after a frame
    send_frame(16'h0F0F, 1'b1, 256);
    send_gap(320, 1'b1);
    check(exp_q.size() == 0, "R7 idle ignored", exp_q.size(), 32'h0);
    send_frame(16'hA5C3, 1'b1, 256);
    send_gap(40, 1'b0);
    check(exp_q.size() == 0, "R7 capture resumes", exp_q.size(), 32'h0);

    // R8 stall consumer through six tagged frames
    check(overflow == 1'b0, "R8 no overflow yet", {31'h0, overflow}, 32'h0);
    sample_ready = 1'b0;
    stall = 1;
    stall_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      send_frame(16'h1000 + 16'(i), 1'b1, 256);
    end
    send_gap(40, 1'b0);
    @(negedge sys_clk);
    check(overflow == 1'b1, "R8 overflow set", {31'h0, overflow}, 32'h1);
    check(sample_valid == 1'b1, "R1 valid while stalled", {31'h0, sample_valid}, 32'h1);
    check(sample_data == 16'h1000, "R1 held word while stalled", {16'h0, sample_data}, 32'h1000);
    stall = 0;
    sample_ready = 1'b1;
    repeat (20) @(posedge sys_clk);
    @(negedge sys_clk);
    check(exp_q.size() == 0, "R8 stored words drained", exp_q.size(), 32'h0);
    check(sample_valid == 1'b0, "R8 nothing beyond depth", {31'h0, sample_valid}, 32'h0);
    check(overflow == 1'b1, "R8 overflow sticky", {31'h0, overflow}, 32'h1);

    // R9 reset clears the sticky flag
    rst_n = 1'b0;
    exp_q.delete();
    repeat (4) @(posedge sys_clk);
    @(negedge sys_clk);
    check(overflow == 1'b0, "R9 overflow cleared", {31'h0, overflow}, 32'h0);
    check(sample_valid == 1'b0, "R9 valid cleared", {31'h0, sample_valid}, 32'h0);
    rst_n = 1'b1;
    send_gap(8, 1'b0);
    send_frame(16'h7E81, 1'b1, 256);
    send_gap(40, 1'b0);
    check(exp_q.size() == 0, "R2 capture after reset", exp_q.size(), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule